// File: doc/BRIEF.md
# Set-Associative Cache Tag Engine

This block models the tag side of a set-associative cache so that the hit, miss and eviction behaviour of an access stream can be measured. It stores no data. A request carries a byte address, a byte count and a read/write flag. The engine breaks the request into the line-sized blocks it touches and looks up one block per clock cycle. It maintains valid, dirty, pinned and timestamp state for every line, and it keeps seven event counters.

A free-running cycle counter supplies the timestamps. When a lookup misses, the engine replaces the line with the oldest timestamp, and it never replaces a pinned line. When the last block of a request has been looked up, the engine pulses `done` and reports how many of the request's blocks were misses that tried to allocate. A separate pin port can lock any line in place. The `wr_alloc_en` input selects whether write misses allocate a line.

Top module: `cte_top`

## Requirements
- R1: `req_ready` is high exactly when the engine is idle. A request accepted at clock edge E0 that spans N blocks is looked up on edges E1 to EN, one block per edge. `done` is high for the single cycle after EN, and the counters are final in that same cycle.
- R2: A request covers the blocks from `req_addr>>log2(LINE_BYTES)` through `(req_addr+req_size-1)>>log2(LINE_BYTES)`. A `req_size` of 0 counts as one byte. `done_misses` equals the number of blocks in the request that missed and attempted allocation: every read miss, plus every write miss while `wr_alloc_en` is 1.
- R3: Block b maps to set `b mod (NUM_LINES/WAYS)`. Each line holds the full block number as its tag, so two blocks that share a set never alias.
- R4: On a hit, the line's timestamp is refreshed and the read-hit or write-hit counter is incremented. A write hit also marks the line dirty.
- R5: A read miss increments the read-miss counter and installs the block.
- R6: A write miss always increments the write-miss counter. When `wr_alloc_en` is 1, the block is installed clean. When `wr_alloc_en` is 0, nothing is installed and the write-around counter is incremented.
- R7: The victim is chosen by scanning the set's ways in order. The first invalid way is taken, even if it is pinned. Otherwise the unpinned way with the smallest timestamp is taken.
- R8: If every way of the set is valid and pinned, the read-around or write-around counter is incremented and nothing is installed.
- R9: Replacing a valid dirty line increments the writeback counter. The installed line is valid, clean and unpinned, and its timestamp is the current cycle.
- R10: When `pin_en` is high, line `pin_line` (line index = set*WAYS + way) becomes pinned at the next edge.
- R11: Reset clears all valid, dirty and pinned bits and all counters, raises `req_ready` and lowers `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_alloc_en | input | 1 | 1: write misses allocate a line |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be accepted |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | SIZE_W | Byte count (0 counts as 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| pin_en | input | 1 | Pin the selected line |
| pin_line | input | log2(NUM_LINES) | Line index to pin |
| done | output | 1 | One-cycle pulse after the last block lookup |
| done_misses | output | SIZE_W+1 | Allocating misses in the finished request |
| cnt_rd_hit | output | CNT_W | Read hits |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_wr_hit | output | CNT_W | Write hits |
| cnt_wr_miss | output | CNT_W | Write misses |
| cnt_writeback | output | CNT_W | Dirty lines evicted |
| cnt_rd_around | output | CNT_W | Read misses left uninstalled |
| cnt_wr_around | output | CNT_W | Write misses left uninstalled |

## Verification
The stimulus repeatedly hits one two-way set with conflicting blocks, so that each replacement is decided by timestamp age. Victims that were refreshed by a hit, dirtied by a write, or freshly installed clean show whether the aging, dirty tracking and writeback counting are correct. Requests that straddle line boundaries, and a zero-byte request, show whether the block range is computed correctly and whether `done` arrives on the right cycle. Write misses with allocation turned on and off, sets with every way pinned, and a set holding a pinned line next to an invalid way show where the around counters and the first-invalid rule apply. A final reset followed by a former hit shows that reset clears the state.

// File: rtl/cte_pkg.sv
package cte_pkg;
  typedef struct packed {
    logic rd_hit;
    logic rd_miss;
    logic wr_hit;
    logic wr_miss;
    logic wb;
    logic rd_around;
    logic wr_around;
    logic alloc_try;
  } cte_evt_t;
  localparam int NUM_EVT = 7;
endpackage

// File: rtl/cte_walker.sv
module cte_walker #(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int OFF_W  = 4,
  parameter int BLK_W  = 12,
  parameter int MISS_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  output logic              lk_valid,
  output logic [BLK_W-1:0]  lk_blk,
  output logic              lk_write,
  input  logic              lk_alloc,
  output logic              done,
  output logic [MISS_W-1:0] done_misses
);
  logic              busy_q, busy_d, wr_q, wr_d, done_q, done_d;
  logic [BLK_W-1:0]  cur_q, cur_d, last_q, last_d;
  logic [MISS_W-1:0] acc_q, acc_d, dmiss_q, dmiss_d;
  logic [ADDR_W-1:0] span, end_addr;

  always_comb begin
    span     = (req_size == '0) ? '0 : ADDR_W'(req_size - 1'b1);
    end_addr = req_addr + span;
    busy_d  = busy_q;
    cur_d   = cur_q;
    last_d  = last_q;
    wr_d    = wr_q;
    acc_d   = acc_q;
    done_d  = 1'b0;
    dmiss_d = dmiss_q;
    if (!busy_q) begin
      if (req_valid) begin
        busy_d = 1'b1;
        cur_d  = req_addr[ADDR_W-1:OFF_W];
        last_d = end_addr[ADDR_W-1:OFF_W];
        wr_d   = req_write;
        acc_d  = '0;
      end
    end else begin
      acc_d = acc_q + MISS_W'(lk_alloc);
      if (cur_q == last_q) begin
        busy_d  = 1'b0;
        done_d  = 1'b1;
        dmiss_d = acc_d;
      end else begin
        cur_d = cur_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      last_q  <= '0;
      wr_q    <= 1'b0;
      acc_q   <= '0;
      done_q  <= 1'b0;
      dmiss_q <= '0;
    end else begin
      busy_q  <= busy_d;
      cur_q   <= cur_d;
      last_q  <= last_d;
      wr_q    <= wr_d;
      acc_q   <= acc_d;
      done_q  <= done_d;
      dmiss_q <= dmiss_d;
    end
  end

  assign req_ready   = !busy_q;
  assign lk_valid    = busy_q;
  assign lk_blk      = cur_q;
  assign lk_write    = wr_q;
  assign done        = done_q;
  assign done_misses = dmiss_q;
endmodule

// File: rtl/cte_tag_store.sv
module cte_tag_store
  import cte_pkg::*;
#(
  parameter int BLK_W     = 12,
  parameter int NUM_LINES = 8,
  parameter int NWAYS     = 2,
  parameter int SETS      = 4,
  parameter int SET_W     = 2,
  parameter int LIDX_W    = 3,
  parameter int TS_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_alloc_en,
  input  logic              lk_valid,
  input  logic [BLK_W-1:0]  lk_blk,
  input  logic              lk_write,
  input  logic [TS_W-1:0]   ts_now,
  input  logic              pin_en,
  input  logic [LIDX_W-1:0] pin_line,
  output cte_evt_t          evt
);
  logic [NUM_LINES-1:0] vld_q, vld_d, dty_q, dty_d, pin_q, pin_d;
  logic [BLK_W-1:0]     tag_q [NUM_LINES];
  logic [BLK_W-1:0]     tag_d [NUM_LINES];
  logic [TS_W-1:0]      ts_q  [NUM_LINES];
  logic [TS_W-1:0]      ts_d  [NUM_LINES];
  logic [SET_W-1:0]     set_idx;
  logic [LIDX_W-1:0]    base, li, hit_line, vic;
  logic                 hit, found, stop;
  logic [TS_W-1:0]      best;

  always_comb begin
    set_idx = lk_blk[SET_W-1:0] & SET_W'(SETS - 1);
    base    = LIDX_W'(int'(set_idx) * NWAYS);
    hit = 1'b0; hit_line = '0;
    found = 1'b0; stop = 1'b0; vic = '0; best = '1;
    for (int w = 0; w < NWAYS; w++) begin
      li = base + LIDX_W'(w);
      if (!hit && vld_q[li] && tag_q[li] == lk_blk) begin
        hit = 1'b1;
        hit_line = li;
      end
      if (!stop) begin
        if (!vld_q[li]) begin
          found = 1'b1; vic = li; stop = 1'b1;
        end else if (!pin_q[li] && (!found || ts_q[li] < best)) begin
          found = 1'b1; vic = li; best = ts_q[li];
        end
      end
    end
  end

  always_comb begin
    vld_d = vld_q; dty_d = dty_q; pin_d = pin_q;
    tag_d = tag_q; ts_d = ts_q;
    evt = '0;
    if (lk_valid) begin
      if (hit) begin
        ts_d[hit_line] = ts_now;
        if (lk_write) begin
          dty_d[hit_line] = 1'b1;
          evt.wr_hit = 1'b1;
        end else begin
          evt.rd_hit = 1'b1;
        end
      end else begin
        evt.wr_miss = lk_write;
        evt.rd_miss = !lk_write;
        if (!lk_write || wr_alloc_en) begin
          evt.alloc_try = 1'b1;
          if (found) begin
            evt.wb     = vld_q[vic] && dty_q[vic];
            vld_d[vic] = 1'b1;
            dty_d[vic] = 1'b0;
            pin_d[vic] = 1'b0;
            tag_d[vic] = lk_blk;
            ts_d[vic]  = ts_now;
          end else begin
            evt.wr_around = lk_write;
            evt.rd_around = !lk_write;
          end
        end else begin
          evt.wr_around = 1'b1;
        end
      end
    end
    if (pin_en) pin_d[pin_line] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
      pin_q <= '0;
    end else begin
      vld_q <= vld_d;
      dty_q <= dty_d;
      pin_q <= pin_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid) begin
      tag_q <= tag_d;
      ts_q  <= ts_d;
    end
  end
endmodule

// File: rtl/cte_stats.sv
module cte_stats
  import cte_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  cte_evt_t                evt,
  output logic [NUM_EVT*CNT_W-1:0] cnt_flat
);
  logic [NUM_EVT-1:0] inc;
  assign inc = {evt.wr_around, evt.rd_around, evt.wb, evt.wr_miss,
                evt.wr_hit, evt.rd_miss, evt.rd_hit};

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q, cnt_d;
    always_comb cnt_d = inc[g] ? cnt_q + 1'b1 : cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/cte_top.sv
module cte_top
  import cte_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 8,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 8,
  parameter int WAYS       = 2,
  parameter int TS_W       = 16,
  parameter int CNT_W      = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int BLK_W     = ADDR_W - OFF_W,
  localparam int NWAYS     = (WAYS == 0) ? NUM_LINES : WAYS,
  localparam int SETS      = NUM_LINES / NWAYS,
  localparam int SET_W     = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int LIDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int MISS_W    = SIZE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_alloc_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  input  logic              pin_en,
  input  logic [LIDX_W-1:0] pin_line,
  output logic              done,
  output logic [MISS_W-1:0] done_misses,
  output logic [CNT_W-1:0]  cnt_rd_hit,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_wr_hit,
  output logic [CNT_W-1:0]  cnt_wr_miss,
  output logic [CNT_W-1:0]  cnt_writeback,
  output logic [CNT_W-1:0]  cnt_rd_around,
  output logic [CNT_W-1:0]  cnt_wr_around
);
  logic [TS_W-1:0]              ts_q;
  logic                         lk_valid, lk_write;
  logic [BLK_W-1:0]             lk_blk;
  cte_evt_t                     evt;
  logic [NUM_EVT*CNT_W-1:0]     cnt_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_q + 1'b1;
  end

  cte_walker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W),
               .BLK_W(BLK_W), .MISS_W(MISS_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .lk_valid(lk_valid), .lk_blk(lk_blk), .lk_write(lk_write),
    .lk_alloc(evt.alloc_try), .done(done), .done_misses(done_misses));

  cte_tag_store #(.BLK_W(BLK_W), .NUM_LINES(NUM_LINES), .NWAYS(NWAYS),
                  .SETS(SETS), .SET_W(SET_W), .LIDX_W(LIDX_W),
                  .TS_W(TS_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .wr_alloc_en(wr_alloc_en),
    .lk_valid(lk_valid), .lk_blk(lk_blk), .lk_write(lk_write),
    .ts_now(ts_q), .pin_en(pin_en), .pin_line(pin_line), .evt(evt));

  cte_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .evt(evt), .cnt_flat(cnt_flat));

  assign cnt_rd_hit    = cnt_flat[0*CNT_W +: CNT_W];
  assign cnt_rd_miss   = cnt_flat[1*CNT_W +: CNT_W];
  assign cnt_wr_hit    = cnt_flat[2*CNT_W +: CNT_W];
  assign cnt_wr_miss   = cnt_flat[3*CNT_W +: CNT_W];
  assign cnt_writeback = cnt_flat[4*CNT_W +: CNT_W];
  assign cnt_rd_around = cnt_flat[5*CNT_W +: CNT_W];
  assign cnt_wr_around = cnt_flat[6*CNT_W +: CNT_W];
endmodule

// File: rtl/cte_checker.sv
module cte_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done,
  input logic [CNT_W-1:0] cnt_rd_hit,
  input logic [CNT_W-1:0] cnt_rd_miss,
  input logic [CNT_W-1:0] cnt_wr_hit,
  input logic [CNT_W-1:0] cnt_wr_miss,
  input logic [CNT_W-1:0] cnt_writeback,
  input logic [CNT_W-1:0] cnt_rd_around,
  input logic [CNT_W-1:0] cnt_wr_around
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!req_ready)); // R1
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> ($stable(cnt_rd_hit) && $stable(cnt_rd_miss) && $stable(cnt_wr_hit) && $stable(cnt_wr_miss))); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cnt_rd_hit != $past(cnt_rd_hit), cnt_rd_miss != $past(cnt_rd_miss), cnt_wr_hit != $past(cnt_wr_hit), cnt_wr_miss != $past(cnt_wr_miss)}) <= 1); // R4
  AST_RD_AROUND_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd_around != $past(cnt_rd_around)) |-> (cnt_rd_miss != $past(cnt_rd_miss))); // R8
  AST_WR_AROUND_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_around != $past(cnt_wr_around)) |-> (cnt_wr_miss != $past(cnt_wr_miss))); // R6
  AST_WB_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_writeback != $past(cnt_writeback)) |-> ((cnt_rd_miss != $past(cnt_rd_miss)) || (cnt_wr_miss != $past(cnt_wr_miss)))); // R9
endmodule

bind cte_top cte_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss),
  .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss),
  .cnt_writeback(cnt_writeback), .cnt_rd_around(cnt_rd_around),
  .cnt_wr_around(cnt_wr_around));

// File: tb/sim_cte_top.sv
`timescale 1ns/1ps
module sim_cte_top;
  logic        clk = 1'b0;
  logic        rst_n, wr_alloc_en, req_valid, req_write, pin_en;
  logic        req_ready, done;
  logic [15:0] req_addr;
  logic [7:0]  req_size;
  logic [2:0]  pin_line;
  logic [8:0]  done_misses;
  logic [15:0] c_rh, c_rm, c_wh, c_wm, c_wb, c_ra, c_wa;

  cte_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_alloc_en(wr_alloc_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .pin_en(pin_en),
    .pin_line(pin_line), .done(done), .done_misses(done_misses),
    .cnt_rd_hit(c_rh), .cnt_rd_miss(c_rm), .cnt_wr_hit(c_wh),
    .cnt_wr_miss(c_wm), .cnt_writeback(c_wb), .cnt_rd_around(c_ra),
    .cnt_wr_around(c_wa));

  always #10 clk = ~clk;

  typedef struct {
    string tag;
    int    miss, cyc;
    int    rh, rm, wh, wm, wb, ra, wa;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nfail = 0, cyc = 0;
  int e_rh = 0, e_rm = 0, e_wh = 0, e_wm = 0, e_wb = 0, e_ra = 0, e_wa = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  // monitor: pops the expected item when done pulses
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk(1'b0, "R1 spurious done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.cyc, "R1 done cycle", cyc, e.cyc);
        chk(int'(done_misses) == e.miss, {e.tag, " misses"}, int'(done_misses), e.miss);
        chk(int'(c_rh) == e.rh, {e.tag, " rd_hit"}, int'(c_rh), e.rh);
        chk(int'(c_rm) == e.rm, {e.tag, " rd_miss"}, int'(c_rm), e.rm);
        chk(int'(c_wh) == e.wh, {e.tag, " wr_hit"}, int'(c_wh), e.wh);
        chk(int'(c_wm) == e.wm, {e.tag, " wr_miss"}, int'(c_wm), e.wm);
        chk(int'(c_wb) == e.wb, {e.tag, " writeback"}, int'(c_wb), e.wb);
        chk(int'(c_ra) == e.ra, {e.tag, " rd_around"}, int'(c_ra), e.ra);
        chk(int'(c_wa) == e.wa, {e.tag, " wr_around"}, int'(c_wa), e.wa);
      end
    end
  end

  task automatic issue(input string tag, input int a, input int sz, input bit w,
                       input int m, input int drh, input int drm, input int dwh,
                       input int dwm, input int dwb, input int dra, input int dwa);
    exp_t e;
    int nb;
    nb = ((a + ((sz == 0) ? 0 : sz - 1)) >> 4) - (a >> 4) + 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e_rh += drh; e_rm += drm; e_wh += dwh; e_wm += dwm;
    e_wb += dwb; e_ra += dra; e_wa += dwa;
    e.tag = tag; e.miss = m; e.cyc = cyc + 1 + nb;
    e.rh = e_rh; e.rm = e_rm; e.wh = e_wh; e.wm = e_wm;
    e.wb = e_wb; e.ra = e_ra; e.wa = e_wa;
    q.push_back(e);
    req_valid = 1'b1; req_addr = 16'(a); req_size = 8'(sz); req_write = w;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic pin(input int line);
    @(negedge clk);
    pin_en = 1'b1; pin_line = 3'(line);
    @(negedge clk);
    pin_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R1 watchdog", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_alloc_en = 1'b1; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_size = '0; pin_en = 1'b0; pin_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready after reset", int'(req_ready), 1);
    chk(done == 1'b0, "R11 done after reset", int'(done), 0);
    chk(c_rm == 16'd0, "R11 counter after reset", int'(c_rm), 0);
    // set0 = blocks 0,4,8,12,16,20 ; line index = set*2 + way
    issue("R5 cold read",        'h000, 4, 0, 1, 0,1,0,0,0,0,0);
    issue("R4 read hit",         'h004, 4, 0, 0, 1,0,0,0,0,0,0);
    issue("R4 write hit",        'h008, 1, 1, 0, 0,0,1,0,0,0,0);
    issue("R7 second way",       'h040, 4, 0, 1, 0,1,0,0,0,0,0);
    issue("R4 refresh",          'h000, 4, 0, 0, 1,0,0,0,0,0,0);
    issue("R7 oldest clean",     'h080, 4, 0, 1, 0,1,0,0,0,0,0);
    issue("R9 dirty evict",      'h040, 4, 0, 1, 0,1,0,0,1,0,0);
    issue("R3 reinstall",        'h000, 4, 0, 1, 0,1,0,0,0,0,0);
    issue("R4 dirty mark",       'h040, 1, 1, 0, 0,0,1,0,0,0,0);
    issue("R9 clean evict",      'h080, 4, 0, 1, 0,1,0,0,0,0,0);
    issue("R2 straddle miss",    'h01C, 8, 0, 2, 0,2,0,0,0,0,0);
    issue("R2 straddle hit",     'h010, 32, 0, 0, 2,0,0,0,0,0,0);
    issue("R2 size zero",        'h03F, 0, 0, 1, 0,1,0,0,0,0,0);
    wr_alloc_en = 1'b0;
    issue("R6 write no alloc",   'h0C0, 4, 1, 0, 0,0,0,1,0,0,1);
    issue("R6 not installed",    'h0C0, 4, 0, 1, 0,1,0,0,1,0,0);
    wr_alloc_en = 1'b1;
    issue("R6 write alloc",      'h100, 4, 1, 1, 0,0,0,1,0,0,0);
    pin(0);
    pin(1);
    issue("R8 read all pinned",  'h140, 4, 0, 1, 0,1,0,0,0,1,0);
    issue("R8 still absent",     'h140, 4, 0, 1, 0,1,0,0,0,1,0);
    issue("R8 write all pinned", 'h140, 4, 1, 1, 0,0,0,1,0,0,1);
    issue("R10 pinned hits",     'h100, 4, 0, 0, 1,0,0,0,0,0,0);
    // set3: way0 holds block 3, way1 invalid
    pin(6);
    pin(7);
    issue("R7 invalid pinned",   'h070, 4, 0, 1, 0,1,0,0,0,0,0);
    issue("R7 installed",        'h070, 4, 0, 0, 1,0,0,0,0,0,0);
    issue("R3 full tag",         'h030, 4, 0, 0, 1,0,0,0,0,0,0);
    issue("R10 skip pinned",     'h0B0, 4, 0, 1, 0,1,0,0,0,0,0);
    issue("R9 install unpinned", 'h070, 4, 0, 1, 0,1,0,0,0,0,0);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(c_rh == 16'd0, "R11 counters cleared", int'(c_rh), 0);
    chk(req_ready == 1'b1, "R11 ready", int'(req_ready), 1);
    e_rh = 0; e_rm = 0; e_wh = 0; e_wm = 0; e_wb = 0; e_ra = 0; e_wa = 0;
    issue("R11 lines invalid",   'h100, 4, 0, 1, 0,1,0,0,0,0,0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule